// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block is a master-side engine that frees a two-wire (I2C-style) bus that a slave has left stuck, for example after a reset in the middle of a transfer. It runs from the system clock and drives the pull-down enables of the open-drain SCL and SDA lines. An enable of 1 pulls the line low. An enable of 0 releases the line, and the external pull-up takes it high.

A one-cycle request pulse starts a fixed pattern. The pattern opens with a start condition. It then gives nine dummy clocks with SDA released, so that a slave part-way through a byte can finish shifting it and let go of the data line. A second start follows, and a stop closes the pattern. After the bus-free interval the block raises a one-cycle done pulse. It also records whether SDA was sensed high at that moment, so that software can tell whether the bus came back.

Every phase length is a cycle count set by parameters. There are two profiles, a standard 400 kHz set and a fast 1 MHz set. The profile is chosen by a select input that is sampled when the request is taken.

Top module: `bus_recover_top`

## Requirements
- R1: After reset both enables are 0 (lines released), busy is 0, done is 0 and the status flag is 0.
- R2: A request taken while idle raises busy. Both lines stay released for the start-setup count. SDA is then pulled low with SCL released, and held so for the start-hold count.
- R3: There are exactly nine clocks. Each has SCL low for the low count with SDA released, and each except the last is followed by SCL released for the high count.
- R4: After the ninth clock, both lines stay released for the high count plus the start-setup count. SDA is then pulled low for the start-hold count with SCL released. SCL is then pulled low for the low count. SCL is then released for the stop-setup count while SDA stays low. Finally SDA is released.
- R5: Both lines stay released for the bus-free count. In the cycle after that count ends, busy falls and done is 1 for exactly one cycle.
- R6: The status flag takes the level of the SDA input sampled at the edge that raises done: 1 means the line was high. The flag holds that value until the next done.
- R7: The select input (1 = fast profile) is sampled with the request and used for the whole sequence. Changing the select input mid-sequence has no effect.
- R8: A request that arrives while busy is 1 is ignored. The sequence timing is unchanged, and only one done pulse results.
- R9: The two enables never change in the same clock cycle. SDA therefore changes only while SCL is steady, and changes while SCL is released only for the two start edges and the stop edge.
- R10: After the first start, SCL is pulled low for one cycle with SDA still low, before SDA is released for the first clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | One-cycle request to run the recovery pattern |
| fastMode | input | 1 | Profile select, 1 = fast timing set |
| sdaIn | input | 1 | Sensed level of the SDA line |
| sclOe | output | 1 | 1 pulls SCL low |
| sdaOe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | A sequence is running |
| donePulse | output | 1 | One-cycle pulse at the end of the sequence |
| sdaHighSeen | output | 1 | SDA level sampled when done was raised |

## Verification
The embedded assertions check the following on every cycle:
- the two enables never toggle together;
- the nine-clock counter stays inside its range;
- the sequence can only be entered from idle;
- done is one cycle wide, finds both lines released, and carries the sampled SDA level into the status flag.

The exact length of every line segment under both profiles can only be shown by the bench scenarios, which compare the segments against a list worked out from the timing counts. The same holds for the ignored mid-run request and select change, and for the status result with a free bus and with a stuck-low bus.

// File: rtl/bus_recover_pkg.sv
package bus_recover_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SU1, ST_HD1, ST_DROP, ST_LOW, ST_HIGH,
    ST_SU2, ST_HD2, ST_STOP_LOW, ST_STOP_SU, ST_FREE
  } seqState_e;

  typedef enum logic [2:0] {
    DUR_ONE, DUR_SU_STA, DUR_HD_STA, DUR_LOW, DUR_HIGH, DUR_SU_STO, DUR_BUF
  } durKind_e;

  typedef struct packed {
    logic     launch;
    logic     load;
    durKind_e kind;
    logic     sclLow;
    logic     sdaLow;
    logic     finish;
  } strobe_t;

endpackage

// File: rtl/bus_recover_ctrl.sv
module bus_recover_ctrl
  import bus_recover_pkg::*;
#(
  parameter int NUM_CLOCKS = 9
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    timerZero,
  output strobe_t strb,
  output logic    busy
);

  localparam int BIT_W = $clog2(NUM_CLOCKS);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(NUM_CLOCKS - 1);

  seqState_e state, nextState;
  logic [BIT_W-1:0] bitCnt, bitNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      state  <= nextState;
      bitCnt <= bitNext;
    end
  end

  always_comb begin
    nextState = state;
    bitNext   = bitCnt;
    strb      = '0;
    unique case (state)
      ST_IDLE: if (startReq) begin
        nextState   = ST_SU1;
        strb.launch = 1'b1;
        strb.load   = 1'b1;
        strb.kind   = DUR_SU_STA;
      end
      ST_SU1: if (timerZero) begin
        nextState   = ST_HD1;
        strb.load   = 1'b1;
        strb.kind   = DUR_HD_STA;
        strb.sdaLow = 1'b1;
      end
      ST_HD1: if (timerZero) begin
        nextState   = ST_DROP;
        strb.load   = 1'b1;
        strb.kind   = DUR_ONE;
        strb.sclLow = 1'b1;
        strb.sdaLow = 1'b1;
      end
      ST_DROP: if (timerZero) begin
        nextState   = ST_LOW;
        bitNext     = '0;
        strb.load   = 1'b1;
        strb.kind   = DUR_LOW;
        strb.sclLow = 1'b1;
      end
      ST_LOW: if (timerZero) begin
        nextState = ST_HIGH;
        strb.load = 1'b1;
        strb.kind = DUR_HIGH;
      end
      ST_HIGH: if (timerZero) begin
        strb.load = 1'b1;
        if (bitCnt == LAST_BIT) begin
          nextState = ST_SU2;
          strb.kind = DUR_SU_STA;
        end else begin
          nextState   = ST_LOW;
          bitNext     = bitCnt + BIT_W'(1);
          strb.kind   = DUR_LOW;
          strb.sclLow = 1'b1;
        end
      end
      ST_SU2: if (timerZero) begin
        nextState   = ST_HD2;
        strb.load   = 1'b1;
        strb.kind   = DUR_HD_STA;
        strb.sdaLow = 1'b1;
      end
      ST_HD2: if (timerZero) begin
        nextState   = ST_STOP_LOW;
        strb.load   = 1'b1;
        strb.kind   = DUR_LOW;
        strb.sclLow = 1'b1;
        strb.sdaLow = 1'b1;
      end
      ST_STOP_LOW: if (timerZero) begin
        nextState   = ST_STOP_SU;
        strb.load   = 1'b1;
        strb.kind   = DUR_SU_STO;
        strb.sdaLow = 1'b1;
      end
      ST_STOP_SU: if (timerZero) begin
        nextState = ST_FREE;
        strb.load = 1'b1;
        strb.kind = DUR_BUF;
      end
      ST_FREE: if (timerZero) begin
        nextState   = ST_IDLE;
        strb.finish = 1'b1;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

  // R3: the dummy clock index never leaves its range
  a_r3_bit_range: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= LAST_BIT);

  // R8: the first setup phase is entered only from idle
  a_r8_entry_from_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SU1 && $past(state) != ST_SU1) |-> $past(state) == ST_IDLE);

endmodule

// File: rtl/bus_recover_dp.sv
module bus_recover_dp
  import bus_recover_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SLOW_LOW    = 163,
  parameter int SLOW_HIGH   = 75,
  parameter int SLOW_SU_STA = 75,
  parameter int SLOW_HD_STA = 75,
  parameter int SLOW_SU_STO = 75,
  parameter int SLOW_BUF    = 163,
  parameter int FAST_LOW    = 50,
  parameter int FAST_HIGH   = 50,
  parameter int FAST_SU_STA = 32,
  parameter int FAST_HD_STA = 32,
  parameter int FAST_SU_STO = 32,
  parameter int FAST_BUF    = 63
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strb,
  input  logic    fastMode,
  input  logic    sdaIn,
  output logic    timerZero,
  output logic    sclOe,
  output logic    sdaOe,
  output logic    donePulse,
  output logic    sdaHighSeen
);

  logic [CNT_W-1:0] cnt, dur;
  logic profFast, useFast;

  assign useFast = strb.launch ? fastMode : profFast;

  always_comb begin
    unique case (strb.kind)
      DUR_SU_STA: dur = useFast ? CNT_W'(FAST_SU_STA) : CNT_W'(SLOW_SU_STA);
      DUR_HD_STA: dur = useFast ? CNT_W'(FAST_HD_STA) : CNT_W'(SLOW_HD_STA);
      DUR_LOW:    dur = useFast ? CNT_W'(FAST_LOW)    : CNT_W'(SLOW_LOW);
      DUR_HIGH:   dur = useFast ? CNT_W'(FAST_HIGH)   : CNT_W'(SLOW_HIGH);
      DUR_SU_STO: dur = useFast ? CNT_W'(FAST_SU_STO) : CNT_W'(SLOW_SU_STO);
      DUR_BUF:    dur = useFast ? CNT_W'(FAST_BUF)    : CNT_W'(SLOW_BUF);
      default:    dur = CNT_W'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt         <= '0;
      profFast    <= 1'b0;
      sclOe       <= 1'b0;
      sdaOe       <= 1'b0;
      donePulse   <= 1'b0;
      sdaHighSeen <= 1'b0;
    end else begin
      donePulse <= strb.finish;
      if (strb.launch) profFast <= fastMode;
      if (strb.load) begin
        cnt   <= dur - CNT_W'(1);
        sclOe <= strb.sclLow;
        sdaOe <= strb.sdaLow;
      end else if (cnt != '0) begin
        cnt <= cnt - CNT_W'(1);
      end
      if (strb.finish) sdaHighSeen <= sdaIn;
    end
  end

  assign timerZero = (cnt == '0);

  // R9: the two line enables never move in the same cycle
  a_r9_no_joint_edge: assert property (@(posedge clk) disable iff (!rstN)
    !((sclOe != $past(sclOe)) && (sdaOe != $past(sdaOe))));

  // R5: done lasts a single cycle
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  // R5: done finds the bus released
  a_r5_done_released: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (!sclOe && !sdaOe));

  // R6: status carries the SDA level seen at the done edge
  a_r6_status_sample: assert property (@(posedge clk) disable iff (!rstN)
    $rose(donePulse) |-> sdaHighSeen == $past(sdaIn));

endmodule

// File: rtl/bus_recover_top.sv
module bus_recover_top
  import bus_recover_pkg::*;
#(
  parameter int NUM_CLOCKS  = 9,
  parameter int CNT_W       = 16,
  parameter int SLOW_LOW    = 163,
  parameter int SLOW_HIGH   = 75,
  parameter int SLOW_SU_STA = 75,
  parameter int SLOW_HD_STA = 75,
  parameter int SLOW_SU_STO = 75,
  parameter int SLOW_BUF    = 163,
  parameter int FAST_LOW    = 50,
  parameter int FAST_HIGH   = 50,
  parameter int FAST_SU_STA = 32,
  parameter int FAST_HD_STA = 32,
  parameter int FAST_SU_STO = 32,
  parameter int FAST_BUF    = 63
) (
  input  logic clk,
  input  logic rstN,
  input  logic startReq,
  input  logic fastMode,
  input  logic sdaIn,
  output logic sclOe,
  output logic sdaOe,
  output logic busy,
  output logic donePulse,
  output logic sdaHighSeen
);

  strobe_t strb;
  logic    timerZero;

  bus_recover_ctrl #(.NUM_CLOCKS(NUM_CLOCKS)) ctrl_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .timerZero(timerZero),
    .strb(strb), .busy(busy)
  );

  bus_recover_dp #(
    .CNT_W(CNT_W),
    .SLOW_LOW(SLOW_LOW), .SLOW_HIGH(SLOW_HIGH), .SLOW_SU_STA(SLOW_SU_STA),
    .SLOW_HD_STA(SLOW_HD_STA), .SLOW_SU_STO(SLOW_SU_STO), .SLOW_BUF(SLOW_BUF),
    .FAST_LOW(FAST_LOW), .FAST_HIGH(FAST_HIGH), .FAST_SU_STA(FAST_SU_STA),
    .FAST_HD_STA(FAST_HD_STA), .FAST_SU_STO(FAST_SU_STO), .FAST_BUF(FAST_BUF)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .fastMode(fastMode), .sdaIn(sdaIn),
    .timerZero(timerZero), .sclOe(sclOe), .sdaOe(sdaOe),
    .donePulse(donePulse), .sdaHighSeen(sdaHighSeen)
  );

endmodule

// File: tb/bus_recover_top_tb_top.sv
module bus_recover_top_tb_top;

  localparam int PER_NS = 8;
  function automatic int cyc(input int ns);
    return (ns + PER_NS - 1) / PER_NS;
  endfunction
  localparam int S_LOW = (1300 + 7) / 8, S_HIGH = (600 + 7) / 8;
  localparam int S_SU = (600 + 7) / 8, S_HD = (600 + 7) / 8;
  localparam int S_SO = (600 + 7) / 8, S_BUF = (1300 + 7) / 8;
  localparam int F_LOW = (400 + 7) / 8, F_HIGH = (400 + 7) / 8;
  localparam int F_SU = (250 + 7) / 8, F_HD = (250 + 7) / 8;
  localparam int F_SO = (250 + 7) / 8, F_BUF = (500 + 7) / 8;

  logic clk = 0, rstN = 0, startReq = 0, fastMode = 0, sdaStuck = 0;
  logic sclOe, sdaOe, busy, donePulse, sdaHighSeen, sdaIn;
  assign sdaIn = ~sdaOe & ~sdaStuck;

  always #4 clk = ~clk;

  bus_recover_top #(
    .SLOW_LOW(S_LOW), .SLOW_HIGH(S_HIGH), .SLOW_SU_STA(S_SU), .SLOW_HD_STA(S_HD),
    .SLOW_SU_STO(S_SO), .SLOW_BUF(S_BUF), .FAST_LOW(F_LOW), .FAST_HIGH(F_HIGH),
    .FAST_SU_STA(F_SU), .FAST_HD_STA(F_HD), .FAST_SU_STO(F_SO), .FAST_BUF(F_BUF)
  ) dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .fastMode(fastMode), .sdaIn(sdaIn),
    .sclOe(sclOe), .sdaOe(sdaOe), .busy(busy), .donePulse(donePulse),
    .sdaHighSeen(sdaHighSeen)
  );

  typedef struct { bit scl; bit sda; int len; string req; } seg_t;
  seg_t expQ[$];
  int compared = 0, mismatched = 0;
  int doneCount = 0, jointEdges = 0;
  bit expStatus = 0, monOn = 0, inRun = 0;
  bit [1:0] runPair, cur;
  int runLen = 0;
  logic prevScl = 0, prevSda = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input bit scl, input bit sda, input int len, input string req);
    seg_t s;
    s.scl = scl; s.sda = sda; s.len = len; s.req = req;
    expQ.push_back(s);
  endtask

  // driver: builds the expected segment list for one sequence
  task automatic push_plan(input bit fast);
    int lo = fast ? cyc(400) : cyc(1300);
    int hi = fast ? cyc(400) : cyc(600);
    int su = fast ? cyc(250) : cyc(600);
    int hd = su;
    int so = su;
    int bf = fast ? cyc(500) : cyc(1300);
    string t = fast ? "R7" : "R2";
    push(1, 1, su, t);
    push(1, 0, hd, t);
    push(0, 0, 1, "R10");
    for (int i = 0; i < 9; i++) begin
      push(0, 1, lo, fast ? "R7" : "R3");
      if (i < 8) push(1, 1, hi, fast ? "R7" : "R3");
    end
    push(1, 1, hi + su, "R4");
    push(1, 0, hd, "R4");
    push(0, 0, lo, "R4");
    push(1, 0, so, "R4");
    push(1, 1, bf, "R5");
  endtask

  task automatic emit(input bit [1:0] pair, input int len);
    seg_t s;
    if (expQ.size() == 0) begin
      check(0, "R3", "unexpected segment length", len, 0);
      return;
    end
    s = expQ.pop_front();
    check({s.scl, s.sda} == pair, s.req, "segment line levels", pair, {s.scl, s.sda});
    check(s.len == len, s.req, "segment length", len, s.len);
  endtask

  // monitor: cuts the busy interval into constant line segments
  always @(negedge clk) begin
    if (monOn) begin
      if ((sclOe != prevScl) && (sdaOe != prevSda)) jointEdges++;
      prevScl = sclOe; prevSda = sdaOe;
      if (donePulse) doneCount++;
      cur = {~sclOe, ~sdaOe};
      if (busy) begin
        if (inRun && cur == runPair) runLen++;
        else begin
          if (inRun) emit(runPair, runLen);
          runPair = cur; runLen = 1; inRun = 1;
        end
      end else if (inRun) begin
        emit(runPair, runLen);
        inRun = 0;
        check(donePulse == 1'b1, "R5", "done with busy fall", donePulse, 1);
        check(sdaHighSeen == expStatus, "R6", "status flag", sdaHighSeen, expStatus);
      end
    end
  end

  task automatic run_seq(input bit fast, input bit stuck, input bit poke);
    int startDone = doneCount;
    push_plan(fast);
    expStatus = !stuck;
    sdaStuck = stuck;
    @(negedge clk);
    fastMode = fast; startReq = 1;
    @(negedge clk);
    startReq = 0;
    if (poke) begin
      repeat (300) @(negedge clk);
      startReq = 1; fastMode = !fast;  // R8 and R7: both must be ignored
      @(negedge clk);
      startReq = 0;
    end
    while (doneCount == startDone) @(negedge clk);
    repeat (50) @(negedge clk);
    check(doneCount == startDone + 1, "R8", "done pulses per request",
          doneCount - startDone, 1);
    check(expQ.size() == 0, "R3", "segments left over", expQ.size(), 0);
    check(busy == 1'b0 && sclOe == 0 && sdaOe == 0, "R5", "idle after run", busy, 0);
    sdaStuck = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(sclOe == 0 && sdaOe == 0, "R1", "enables in reset", {sclOe, sdaOe}, 0);
    check(busy == 0 && donePulse == 0, "R1", "busy/done in reset", {busy, donePulse}, 0);
    rstN = 1;
    @(negedge clk);
    check(sdaHighSeen == 0, "R1", "status after reset", sdaHighSeen, 0);
    monOn = 1;
    run_seq(0, 0, 0);
    run_seq(1, 1, 0);
    run_seq(0, 0, 1);
    run_seq(1, 0, 1);
    check(jointEdges == 0, "R9", "cycles with both enables changing", jointEdges, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule